// File: doc/BRIEF.md
# Smooth Vertical Scroll Address Generator

This block forms the video memory byte address for a character-based raster display. Software sets a coarse start position in character units, a 16 KB bank, and a 3-bit fine offset through a small write port. The raster side supplies the current scanline within a character row, the row index and the column index. Each cycle the block turns these into a registered 16-bit address.

Coarse scrolling moves the start by a whole character row of 40 characters, which is 8 scanlines. The fine offset is added to the raster scanline, so the picture can move one scanline at a time. When the sum of the two passes 7, the address steps into the next character row. Register writes land in holding registers. They are copied into the working set only on a frame-start pulse, so a write never changes a frame that is already being drawn.

Top module: `scroll_addr_gen`

## Requirements
- R1: While `rst` is high, `addr` is 0 and the working settings (bank, start, fine) are 0. With all raster inputs at 0 after reset, `addr` stays 0.
- R2: A write with `wr_en` high stores `wr_data` by `wr_sel`: 0 = start high byte, 1 = start low byte, 2 = fine-scroll byte. `wr_sel` 3 changes nothing.
- R3: Written values act on `addr` only after a later `frame_start` pulse. Between pulses, the working settings hold their values.
- R4: Bits 5:4 of the start high byte select the bank, and the bank appears on `addr[15:14]` (0 = 0000h, 1 = 4000h, 2 = 8000h, 3 = C000h).
- R5: The character start is 10 bits, formed as {high byte bits 1:0, low byte}. High byte bits 7:6 and 3:2 have no effect.
- R6: The fine offset is bits 6:4 of the fine-scroll byte. `addr[13:11]` equals (`scan_cnt` + fine) mod 8.
- R7: When `scan_cnt` + fine is 8 or more, the character address moves forward by one row (40 characters).
- R8: The character address is (start + row_eff × 40 + `col_cnt`) mod 1024, where row_eff is `row_cnt` plus the R7 carry. `addr[10:0]` equals character address × 2 + `byte_sel`.
- R9: `addr` reflects the inputs sampled at the previous rising clock edge, one register stage.
- R10: A write in the same cycle as `frame_start` is not used for the frame that starts. It takes effect at the next `frame_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (0 start high, 1 start low, 2 fine, 3 none) |
| wr_data | input | 8 | Write data |
| frame_start | input | 1 | Pulse at vertical sync start; loads the working settings |
| scan_cnt | input | 3 | Raster scanline within the character row |
| row_cnt | input | 5 | Character row index on screen |
| col_cnt | input | 6 | Character column index in the row |
| byte_sel | input | 1 | Byte within a 2-byte character |
| addr | output | 16 | Registered video memory byte address |

## Verification
Every raster vector produces its address one rising edge after it is driven. The driver applies a vector at a falling edge and pushes the expected address into a queue. The monitor pops that entry 2 ns after the next rising edge, which keeps the comparison well away from the edge itself.

A register write takes effect only through a `frame_start` pulse. For that reason, vectors that follow a write, but come before the pulse, expect the old settings. This is how R3 and R10 are shown at the output. The wrap past 1023, the row carry from the fine offset, and the ignored high-byte bits each get vectors of their own.

// File: rtl/scroll_pkg.sv
package scroll_pkg;

  typedef enum logic [1:0] {
    SEL_START_HI = 2'd0,
    SEL_START_LO = 2'd1,
    SEL_FINE     = 2'd2,
    SEL_NONE     = 2'd3
  } reg_sel_e;

  // Working settings used for one whole frame
  typedef struct packed {
    logic [1:0] bank;
    logic [9:0] start;
    logic [2:0] fine;
  } frame_cfg_t;

endpackage

// File: rtl/scroll_regs.sv
module scroll_regs #(
  parameter int DATA_W = 8,
  parameter int N_REGS = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [1:0]                wr_sel,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic                      frame_start,
  output scroll_pkg::frame_cfg_t    cfg
);
  import scroll_pkg::*;

  logic [DATA_W-1:0] hold [N_REGS];

  // One holding register per selectable address
  for (genvar i = 0; i < N_REGS; i++) begin : g_hold
    always_ff @(posedge clk) begin
      if (rst)
        hold[i] <= '0;
      else if (wr_en && (wr_sel == 2'(i)))
        hold[i] <= wr_data;
    end
  end

  // Frame-start copy: the same-cycle write is not visible here yet
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else if (frame_start) begin
      cfg.bank  <= hold[SEL_START_HI][5:4];
      cfg.start <= {hold[SEL_START_HI][1:0], hold[SEL_START_LO][7:0]};
      cfg.fine  <= hold[SEL_FINE][6:4];
    end
  end

endmodule

// File: rtl/scroll_addr_calc.sv
module scroll_addr_calc #(
  parameter int ROW_CHARS = 40,
  parameter int ROW_W     = 5,
  parameter int COL_W     = 6
) (
  input  scroll_pkg::frame_cfg_t cfg,
  input  logic [2:0]             scan_cnt,
  input  logic [ROW_W-1:0]       row_cnt,
  input  logic [COL_W-1:0]       col_cnt,
  input  logic                   byte_sel,
  output logic [15:0]            addr_next
);
  localparam int CHAR_W = 10;

  logic [3:0]       scan_sum;
  logic [ROW_W:0]   row_eff;
  logic [31:0]      char_full;
  logic [CHAR_W-1:0] char_addr;

  always_comb begin
    scan_sum  = {1'b0, scan_cnt} + {1'b0, cfg.fine};
    row_eff   = {1'b0, row_cnt} + (ROW_W+1)'(scan_sum[3]);
    char_full = 32'(cfg.start) + 32'(row_eff) * 32'(ROW_CHARS) + 32'(col_cnt);
    char_addr = char_full[CHAR_W-1:0];
    addr_next = {cfg.bank, scan_sum[2:0], char_addr, byte_sel};
  end

endmodule

// File: rtl/scroll_addr_gen.sv
module scroll_addr_gen #(
  parameter int ROW_CHARS = 40,
  parameter int ROW_W     = 5,
  parameter int COL_W     = 6,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              frame_start,
  input  logic [2:0]        scan_cnt,
  input  logic [ROW_W-1:0]  row_cnt,
  input  logic [COL_W-1:0]  col_cnt,
  input  logic              byte_sel,
  output logic [15:0]       addr
);
  import scroll_pkg::*;

  frame_cfg_t  cfg;
  logic [15:0] addr_next;

  scroll_regs #(.DATA_W(DATA_W), .N_REGS(3)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .frame_start (frame_start),
    .cfg         (cfg)
  );

  scroll_addr_calc #(.ROW_CHARS(ROW_CHARS), .ROW_W(ROW_W), .COL_W(COL_W)) u_calc (
    .cfg       (cfg),
    .scan_cnt  (scan_cnt),
    .row_cnt   (row_cnt),
    .col_cnt   (col_cnt),
    .byte_sel  (byte_sel),
    .addr_next (addr_next)
  );

  always_ff @(posedge clk) begin
    if (rst) addr <= '0;
    else     addr <= addr_next;
  end

endmodule

// File: rtl/scroll_addr_chk.sv
module scroll_addr_chk (
  input logic                   clk,
  input logic                   rst,
  input logic                   frame_start,
  input logic [2:0]             scan_cnt,
  input logic                   byte_sel,
  input logic [15:0]            addr,
  input scroll_pkg::frame_cfg_t cfg
);
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  assert_reset_zero_R1: assert property (@(posedge clk)
    rst |=> (addr == 16'h0000));

  assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> $stable(cfg));

  assert_bank_out_R4: assert property (@(posedge clk) disable iff (rst)
    armed |-> (addr[15:14] == $past(cfg.bank)));

  assert_fine_scan_R6: assert property (@(posedge clk) disable iff (rst)
    armed |-> (addr[13:11] == 3'($past(scan_cnt) + $past(cfg.fine))));

  assert_byte_lsb_R8: assert property (@(posedge clk) disable iff (rst)
    armed |-> (addr[0] == $past(byte_sel)));

endmodule

bind scroll_addr_gen scroll_addr_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .frame_start (frame_start),
  .scan_cnt    (scan_cnt),
  .byte_sel    (byte_sel),
  .addr        (addr),
  .cfg         (cfg)
);

// File: tb/scroll_addr_gen_bench.sv
module scroll_addr_gen_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [7:0]  wr_data = 8'd0;
  logic        frame_start = 1'b0;
  logic [2:0]  scan_cnt = 3'd0;
  logic [4:0]  row_cnt = 5'd0;
  logic [5:0]  col_cnt = 6'd0;
  logic        byte_sel = 1'b0;
  logic [15:0] addr;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // Model state: holding and working copies
  logic [7:0] m_hi = 8'd0, m_lo = 8'd0, m_fine = 8'd0;
  logic [1:0] w_bank = 2'd0;
  logic [9:0] w_start = 10'd0;
  logic [2:0] w_fine = 3'd0;

  typedef struct {
    logic [15:0] exp;
    string       req;
  } item_t;
  item_t sb[$];

  always #10 clk = ~clk;

  scroll_addr_gen u_scroll_addr_gen (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .frame_start(frame_start), .scan_cnt(scan_cnt), .row_cnt(row_cnt),
    .col_cnt(col_cnt), .byte_sel(byte_sel), .addr(addr)
  );

  function automatic logic [15:0] model(input logic [2:0] s, input logic [4:0] r,
                                        input logic [5:0] c, input logic b);
    int sum;
    int ch;
    sum = int'(s) + int'(w_fine);
    ch  = (int'(w_start) + (int'(r) + sum / 8) * 40 + int'(c)) % 1024;
    return {w_bank, 3'(sum % 8), 10'(ch), b};
  endfunction

  task automatic apply(input logic [2:0] s, input logic [4:0] r,
                       input logic [5:0] c, input logic b, input string req);
    item_t it;
    @(negedge clk);
    scan_cnt = s; row_cnt = r; col_cnt = c; byte_sel = b;
    it.exp = model(s, r, c, b);
    it.req = req;
    sb.push_back(it);
  endtask

  task automatic hold_store(input logic [1:0] sel, input logic [7:0] d);
    case (sel)
      2'd0: m_hi = d;
      2'd1: m_lo = d;
      2'd2: m_fine = d;
      default: ;
    endcase
  endtask

  task automatic load_cfg();
    w_bank  = m_hi[5:4];
    w_start = {m_hi[1:0], m_lo};
    w_fine  = m_fine[6:4];
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    hold_store(sel, d);
  endtask

  task automatic frame(input bit with_wr, input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    frame_start = 1'b1;
    if (with_wr) begin wr_en = 1'b1; wr_sel = sel; wr_data = d; end
    @(negedge clk);
    frame_start = 1'b0; wr_en = 1'b0;
    load_cfg();
    if (with_wr) hold_store(sel, d);
  endtask

  // Monitor: result due one rising edge after the vector is driven
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      n_checks++;
      if (addr !== it.exp) begin
        n_fail++;
        $display("FAIL %s: addr=%h expected=%h", it.req, addr, it.exp);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_checks++;
    if (addr !== 16'h0000) begin
      n_fail++;
      $display("FAIL R1: addr=%h expected=%h during reset", addr, 16'h0000);
    end
    rst = 1'b0;
    apply(3'd0, 5'd0, 6'd0, 1'b0, "R1");
    apply(3'd2, 5'd1, 6'd3, 1'b1, "R9");
    apply(3'd7, 5'd24, 6'd39, 1'b1, "R8");

    // R3: written but not yet loaded
    wr(2'd1, 8'h05);
    wr(2'd0, 8'h10);
    apply(3'd1, 5'd0, 6'd0, 1'b0, "R3");
    frame(1'b0, 2'd0, 8'h00);
    apply(3'd1, 5'd0, 6'd0, 1'b0, "R3");
    apply(3'd0, 5'd2, 6'd4, 1'b1, "R4");

    // R5: ignored high-byte bits, bank 0, start 3xx
    wr(2'd0, 8'hCF);
    wr(2'd1, 8'h10);
    frame(1'b0, 2'd0, 8'h00);
    apply(3'd0, 5'd0, 6'd0, 1'b0, "R5");

    // R8 wrap past 1023 with bank 3
    wr(2'd0, 8'h33);
    wr(2'd1, 8'hE8);
    frame(1'b0, 2'd0, 8'h00);
    apply(3'd3, 5'd1, 6'd5, 1'b0, "R8");
    apply(3'd0, 5'd0, 6'd23, 1'b1, "R8");

    // R6/R7: fine offset 5 (bits 6:4), other bits set
    wr(2'd2, 8'hDF);
    frame(1'b0, 2'd0, 8'h00);
    apply(3'd2, 5'd0, 6'd0, 1'b0, "R6");
    apply(3'd3, 5'd4, 6'd1, 1'b0, "R7");
    apply(3'd7, 5'd2, 6'd10, 1'b1, "R7");

    // R2: select 3 changes nothing
    wr(2'd3, 8'hFF);
    frame(1'b0, 2'd0, 8'h00);
    apply(3'd4, 5'd3, 6'd2, 1'b0, "R2");

    // R10: write in the frame-start cycle waits one frame
    frame(1'b1, 2'd0, 8'h20);
    apply(3'd0, 5'd0, 6'd0, 1'b0, "R10");
    frame(1'b0, 2'd0, 8'h00);
    apply(3'd0, 5'd0, 6'd0, 1'b0, "R10");

    // R1 again: reset clears working settings
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    m_hi = 0; m_lo = 0; m_fine = 0; load_cfg();
    apply(3'd0, 5'd0, 6'd0, 1'b0, "R1");
    frame(1'b0, 2'd0, 8'h00);
    apply(3'd6, 5'd1, 6'd0, 1'b0, "R1");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: addr=%h expected=completion", addr);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule